// File: doc/BRIEF.md
# Configuration Data Window Bridge

The bridge sits between a host register port and a downstream configuration-space bus. The host reaches two things through it. The first is a 32-bit address register that it can write and read back. The second is a data window, and each access to the window becomes a single downstream transaction. The top bit of the address register works as a forwarding switch. When the switch is clear, window writes disappear and window reads complete locally with an all-ones value sized to the access.

Window accesses may be byte, halfword or word wide. For sub-word accesses, the downstream address is the address register with the two low window address bits merged in. Word accesses use the register exactly as written. A static mode input selects big-endian hosts. In that mode, halfword and word data is byte-reversed on the way down and on the way back up.

Only one host access is in flight at a time. The host pulses `host_req_valid` for one cycle while the bridge is idle, then waits for the one-cycle `host_ack` pulse. A write needs only the downstream request handshake to complete. A read also waits for the downstream response.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the address register reads 0. A host write with `host_sel_data`=0 stores the full 32-bit word, and a later read with `host_sel_data`=0 returns that word. The access size is ignored for this register.
- R2: While bit 31 of the address register is 0, a window write (`host_sel_data`=1, `host_we`=1) is acknowledged but issues no downstream request.
- R3: While bit 31 is 0, a window read returns all ones at the access width, zero-extended. Size code 0 (byte) returns 0x000000FF, code 1 (halfword) returns 0x0000FFFF, and code 2 (word) returns 0xFFFFFFFF.
- R4: For byte and halfword window accesses, `ds_addr` equals the address register ORed with `host_win_low`.
- R5: For word window accesses (size code 2 or 3), `ds_addr` equals the address register unchanged, whatever the value of `host_win_low`.
- R6: `ds_size` is 1, 2 or 4 for size codes 0, 1 and 2/3 respectively. Write data travels right-aligned in `ds_wdata`, with the bytes above the access width forced to 0.
- R7: With `host_big_endian`=0, write data is not reordered. With `host_big_endian`=1, halfword write data has its two low bytes exchanged and word write data has its four bytes reversed. Byte write data is never reordered.
- R8: Read data is taken right-aligned from `ds_rsp_rdata` and masked to the access width. With `host_big_endian`=1, halfword and word read data is byte-reversed in the same way as R7. Byte read data is never reordered.
- R9: `ds_req_valid` and its address, size, write flag and data stay stable until `ds_req_ready` is seen. A window read is acknowledged only in the cycle after `ds_rsp_valid`. `host_ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_big_endian | input | 1 | Static mode: 1 enables byte reordering of halfword and word data |
| host_req_valid | input | 1 | One-cycle host request pulse, accepted while idle |
| host_sel_data | input | 1 | 0 selects the address register, 1 selects the data window |
| host_win_low | input | 2 | Low data-window address bits |
| host_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 or 3 word |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_ack |
| ds_req_valid | output | 1 | Downstream request valid |
| ds_req_ready | input | 1 | Downstream request accepted |
| ds_addr | output | 32 | Downstream configuration address |
| ds_size | output | 3 | Downstream byte count: 1, 2 or 4 |
| ds_we | output | 1 | Downstream write flag |
| ds_wdata | output | 32 | Downstream write data |
| ds_rsp_valid | input | 1 | Downstream read response valid |
| ds_rsp_rdata | input | 32 | Downstream read response data |

## Verification
Window accesses made while forwarding is off are checked at every width. A bridge that forwarded anyway would show extra downstream requests. One that returned a fixed 32-bit all-ones would return the wrong halfword and byte values.

Address formation is tested with nonzero low window bits on both sub-word and word accesses. A bridge that merged the bits on a word access would drive a misaligned address.

Both endian modes are run at all three widths with asymmetric data patterns. A swap applied to bytes, or a swap missing for halfwords, shows up directly.

A read against a slow responder checks that the request stays stable through the stall and that the acknowledge waits for the response. A bridge that acknowledged on request acceptance would complete too early.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } cfgw_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } cfgw_state_e;

  // Map a raw 2-bit code onto a legal size; the reserved code means word.
  function automatic cfgw_size_e sanitize_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/cfgw_addr_reg.sv
module cfgw_addr_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data;
    end
  end

endmodule

// File: rtl/cfgw_lane_swap.sv
module cfgw_lane_swap
  import cfgw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  cfgw_size_e    size,
  input  logic          swap_en,
  output logic [DW-1:0] dout
);

  localparam int NB = DW / 8;

  int nbytes;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      default: nbytes = 4;
    endcase
    if (nbytes > NB) nbytes = NB;
  end

  // Each output lane either mirrors its own input lane, picks the mirrored
  // lane inside the access width, or is forced to zero above the width.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_val;
    always_comb begin
      int src;
      src = swap_en ? (nbytes - 1 - g) : g;
      lane_val = '0;
      if (g < nbytes && src >= 0 && src < NB) begin
        lane_val = din[8*src +: 8];
      end
    end
    assign dout[8*g +: 8] = lane_val;
  end

endmodule

// File: rtl/cfgw_ctrl.sv
module cfgw_ctrl
  import cfgw_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LOWW = 2,
  parameter int SZW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_sel_data,
  input  logic [LOWW-1:0] req_low,
  input  cfgw_size_e      req_size,
  input  logic            req_we,
  input  logic [DW-1:0]   req_wdata_fmt,
  input  logic [DW-1:0]   cfg_addr_q,
  output logic            addr_wr_en,
  input  logic            ds_req_ready,
  input  logic            ds_rsp_valid,
  input  logic [DW-1:0]   rsp_fmt,
  output logic            ds_req_valid,
  output logic [DW-1:0]   ds_addr,
  output logic [SZW-1:0]  ds_size,
  output logic            ds_we,
  output logic [DW-1:0]   ds_wdata,
  output logic            host_ack,
  output logic [DW-1:0]   host_rdata,
  output cfgw_size_e      size_q
);

  localparam int EN_BIT = DW - 1;

  cfgw_state_e state;

  logic [DW-1:0]  ones_mask;
  logic [SZW-1:0] size_bytes;
  logic [DW-1:0]  fwd_addr;

  always_comb begin
    addr_wr_en = (state == ST_IDLE) && req_valid && !req_sel_data && req_we;
    for (int i = 0; i < DW; i++) begin
      ones_mask[i] = (i < (8 << int'(req_size)));
    end
    case (req_size)
      SZ_BYTE: size_bytes = SZW'(1);
      SZ_HALF: size_bytes = SZW'(2);
      default: size_bytes = SZW'(4);
    endcase
    if (req_size == SZ_WORD) fwd_addr = cfg_addr_q;
    else                     fwd_addr = cfg_addr_q | DW'(req_low);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ds_req_valid <= 1'b0;
      ds_addr      <= '0;
      ds_size      <= '0;
      ds_we        <= 1'b0;
      ds_wdata     <= '0;
      host_ack     <= 1'b0;
      host_rdata   <= '0;
      size_q       <= SZ_BYTE;
    end else begin
      host_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            size_q <= req_size;
            if (!req_sel_data) begin
              host_ack <= 1'b1;
              if (!req_we) host_rdata <= cfg_addr_q;
            end else if (!cfg_addr_q[EN_BIT]) begin
              host_ack <= 1'b1;
              if (!req_we) host_rdata <= ones_mask;
            end else begin
              ds_req_valid <= 1'b1;
              ds_addr      <= fwd_addr;
              ds_size      <= size_bytes;
              ds_we        <= req_we;
              ds_wdata     <= req_we ? req_wdata_fmt : '0;
              state        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (ds_req_ready) begin
            ds_req_valid <= 1'b0;
            if (ds_we) begin
              host_ack <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (ds_rsp_valid) begin
            host_ack   <= 1'b1;
            host_rdata <= rsp_fmt;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: no downstream request unless the enable bit of the register is set
  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    ds_req_valid |-> cfg_addr_q[EN_BIT]);

  // R5: a word request carries the register value unchanged
  assert_word_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (ds_req_valid && ds_size == SZW'(4)) |-> ds_addr == cfg_addr_q);

  // R6: the byte count is always a single power of two
  assert_size_code_R6: assert property (@(posedge clk) disable iff (rst)
    ds_req_valid |-> $countones(ds_size) == 1);

  // R9: request held stable while stalled
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ds_req_valid && !ds_req_ready) |=>
      (ds_req_valid && $stable(ds_addr) && $stable(ds_wdata) && $stable(ds_size) && $stable(ds_we)));

  // R9: no read acknowledge before the response
  assert_rsp_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ds_rsp_valid) |=> !host_ack);

  // R9: acknowledge is a single-cycle pulse
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgw_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LOWW = $clog2(DW / 8),
  parameter int SZW  = $clog2(DW / 8) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_big_endian,
  input  logic            host_req_valid,
  input  logic            host_sel_data,
  input  logic [LOWW-1:0] host_win_low,
  input  logic [1:0]      host_size,
  input  logic            host_we,
  input  logic [DW-1:0]   host_wdata,
  output logic            host_ack,
  output logic [DW-1:0]   host_rdata,
  output logic            ds_req_valid,
  input  logic            ds_req_ready,
  output logic [DW-1:0]   ds_addr,
  output logic [SZW-1:0]  ds_size,
  output logic            ds_we,
  output logic [DW-1:0]   ds_wdata,
  input  logic            ds_rsp_valid,
  input  logic [DW-1:0]   ds_rsp_rdata
);

  cfgw_size_e    req_size;
  cfgw_size_e    size_q;
  logic [DW-1:0] cfg_addr_q;
  logic          addr_wr_en;
  logic [DW-1:0] wdata_fmt;
  logic [DW-1:0] rsp_fmt;

  assign req_size = sanitize_size(host_size);

  cfgw_addr_reg #(.DW(DW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (addr_wr_en),
    .wr_data (host_wdata),
    .q       (cfg_addr_q)
  );

  cfgw_lane_swap #(.DW(DW)) u_wr_fmt (
    .din     (host_wdata),
    .size    (req_size),
    .swap_en (host_big_endian),
    .dout    (wdata_fmt)
  );

  cfgw_lane_swap #(.DW(DW)) u_rd_fmt (
    .din     (ds_rsp_rdata),
    .size    (size_q),
    .swap_en (host_big_endian),
    .dout    (rsp_fmt)
  );

  cfgw_ctrl #(.DW(DW), .LOWW(LOWW), .SZW(SZW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (host_req_valid),
    .req_sel_data  (host_sel_data),
    .req_low       (host_win_low),
    .req_size      (req_size),
    .req_we        (host_we),
    .req_wdata_fmt (wdata_fmt),
    .cfg_addr_q    (cfg_addr_q),
    .addr_wr_en    (addr_wr_en),
    .ds_req_ready  (ds_req_ready),
    .ds_rsp_valid  (ds_rsp_valid),
    .rsp_fmt       (rsp_fmt),
    .ds_req_valid  (ds_req_valid),
    .ds_addr       (ds_addr),
    .ds_size       (ds_size),
    .ds_we         (ds_we),
    .ds_wdata      (ds_wdata),
    .host_ack      (host_ack),
    .host_rdata    (host_rdata),
    .size_q        (size_q)
  );

endmodule

// File: tb/cfg_window_bridge_tb_top.sv
module cfg_window_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0;
  logic        rst = 1;
  logic        host_big_endian = 0;
  logic        host_req_valid = 0;
  logic        host_sel_data = 0;
  logic [1:0]  host_win_low = 0;
  logic [1:0]  host_size = 0;
  logic        host_we = 0;
  logic [31:0] host_wdata = 0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        ds_req_valid;
  logic        ds_req_ready;
  logic [31:0] ds_addr;
  logic [2:0]  ds_size;
  logic        ds_we;
  logic [31:0] ds_wdata;
  logic        ds_rsp_valid;
  logic [31:0] ds_rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_bridge dut_i (
    .clk(clk), .rst(rst), .host_big_endian(host_big_endian),
    .host_req_valid(host_req_valid), .host_sel_data(host_sel_data),
    .host_win_low(host_win_low), .host_size(host_size), .host_we(host_we),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready), .ds_addr(ds_addr),
    .ds_size(ds_size), .ds_we(ds_we), .ds_wdata(ds_wdata),
    .ds_rsp_valid(ds_rsp_valid), .ds_rsp_rdata(ds_rsp_rdata)
  );

  // Downstream model
  int          cyc = 0;
  int          rdy_wait = 0;
  int          rsp_wait = 0;
  logic [31:0] rsp_data = 0;
  int          wcnt = 0, rcnt = 0;
  logic        rdy = 0, pend = 0, rsp_v = 0;
  logic [31:0] rsp_d = 0;
  int          accepts = 0, rsp_cyc = 0, hold_bad = 0;
  logic [31:0] last_addr = 0, last_wdata = 0;
  logic [2:0]  last_size = 0;
  logic        last_we = 0;
  logic        stalled = 0;
  logic [31:0] stall_addr = 0;

  assign ds_req_ready = rdy;
  assign ds_rsp_valid = rsp_v;
  assign ds_rsp_rdata = rsp_d;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst) begin
      rdy <= 0; pend <= 0; rsp_v <= 0; wcnt <= 0; rcnt <= 0; stalled <= 0;
    end else begin
      if (stalled && ds_addr != stall_addr) hold_bad <= hold_bad + 1;
      stalled    <= ds_req_valid && !ds_req_ready;
      stall_addr <= ds_addr;
      if (ds_req_valid && ds_req_ready) begin
        accepts    <= accepts + 1;
        last_addr  <= ds_addr;
        last_size  <= ds_size;
        last_we    <= ds_we;
        last_wdata <= ds_wdata;
        rdy  <= 0;
        wcnt <= 0;
        if (!ds_we) begin pend <= 1; rcnt <= 0; end
      end else if (ds_req_valid && !rdy) begin
        if (wcnt >= rdy_wait) rdy <= 1;
        else wcnt <= wcnt + 1;
      end
      rsp_v <= 0;
      if (pend) begin
        if (rcnt >= rsp_wait) begin
          rsp_v <= 1; rsp_d <= rsp_data; pend <= 0; rsp_cyc <= cyc;
        end else rcnt <= rcnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  int ack_cyc = 0;

  task automatic access(input bit sel, input logic [1:0] low, input logic [1:0] sz,
                        input bit we, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req_valid = 1; host_sel_data = sel; host_win_low = low;
    host_size = sz; host_we = we; host_wdata = wd;
    @(negedge clk);
    host_req_valid = 0;
    while (!host_ack) @(negedge clk);
    rd = host_rdata;
    ack_cyc = cyc;
  endtask

  task automatic set_addr(input logic [31:0] v);
    logic [31:0] d;
    access(0, 0, 2, 1, v, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9", "ack after reset", 32'(host_ack), 0);
    chk("R2", "req valid after reset", 32'(ds_req_valid), 0);
    access(0, 0, 2, 0, 0, d);
    chk("R1", "addr reg reset value", d, 0);
  endtask

  task automatic t_addr_reg();
    logic [31:0] d;
    access(0, 0, 0, 1, 32'h8001_0800, d);
    access(0, 0, 0, 0, 0, d);
    chk("R1", "addr reg readback", d, 32'h8001_0800);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    int a0;
    set_addr(32'h0001_0800);
    a0 = accepts;
    access(1, 1, 0, 1, 32'h11, d);
    access(1, 2, 1, 1, 32'h2222, d);
    access(1, 0, 2, 1, 32'h3333_3333, d);
    repeat (4) @(negedge clk);
    chk("R2", "requests while disabled", 32'(accepts - a0), 0);
    access(1, 3, 0, 0, 0, d); chk("R3", "disabled byte read", d, 32'h0000_00FF);
    access(1, 2, 1, 0, 0, d); chk("R3", "disabled half read", d, 32'h0000_FFFF);
    access(1, 0, 2, 0, 0, d); chk("R3", "disabled word read", d, 32'hFFFF_FFFF);
    chk("R2", "requests after disabled reads", 32'(accepts - a0), 0);
  endtask

  task automatic t_addr_form();
    logic [31:0] d;
    host_big_endian = 0;
    set_addr(32'h8001_0800);
    access(1, 3, 0, 1, 32'h1234_56A5, d);
    chk("R4", "byte addr", last_addr, 32'h8001_0803);
    chk("R6", "byte size", 32'(last_size), 1);
    chk("R6", "byte wdata masked", last_wdata, 32'h0000_00A5);
    access(1, 2, 1, 1, 32'hFFFF_1234, d);
    chk("R4", "half addr", last_addr, 32'h8001_0802);
    chk("R6", "half size", 32'(last_size), 2);
    chk("R7", "le half wdata", last_wdata, 32'h0000_1234);
    access(1, 3, 2, 1, 32'hCAFE_F00D, d);
    chk("R5", "word addr ignores low bits", last_addr, 32'h8001_0800);
    chk("R6", "word size", 32'(last_size), 4);
    chk("R7", "le word wdata", last_wdata, 32'hCAFE_F00D);
    access(1, 1, 3, 1, 32'h0, d);
    chk("R5", "reserved code addr", last_addr, 32'h8001_0800);
    chk("R6", "reserved code size", 32'(last_size), 4);
  endtask

  task automatic t_le_read();
    logic [31:0] d;
    host_big_endian = 0;
    rsp_data = 32'h1122_3344;
    access(1, 0, 2, 0, 0, d); chk("R8", "le word read", d, 32'h1122_3344);
    chk("R6", "read write flag", 32'(last_we), 0);
    access(1, 2, 1, 0, 0, d); chk("R8", "le half read masked", d, 32'h0000_3344);
    access(1, 1, 0, 0, 0, d); chk("R8", "le byte read masked", d, 32'h0000_0044);
  endtask

  task automatic t_be();
    logic [31:0] d;
    host_big_endian = 1;
    access(1, 0, 0, 1, 32'h0000_005A, d); chk("R7", "be byte not swapped", last_wdata, 32'h0000_005A);
    access(1, 0, 1, 1, 32'h0000_BEEF, d); chk("R7", "be half swap", last_wdata, 32'h0000_EFBE);
    access(1, 0, 2, 1, 32'h0102_0304, d); chk("R7", "be word swap", last_wdata, 32'h0403_0201);
    rsp_data = 32'hAABB_CCDD;
    access(1, 0, 2, 0, 0, d); chk("R8", "be word read", d, 32'hDDCC_BBAA);
    access(1, 0, 1, 0, 0, d); chk("R8", "be half read", d, 32'h0000_DDCC);
    access(1, 0, 0, 0, 0, d); chk("R8", "be byte read", d, 32'h0000_00DD);
    host_big_endian = 0;
  endtask

  task automatic t_stall();
    logic [31:0] d;
    rdy_wait = 3; rsp_wait = 4; rsp_data = 32'h5566_7788;
    hold_bad = 0;
    access(1, 1, 0, 0, 0, d);
    chk("R9", "stalled read data", d, 32'h0000_0088);
    chk("R9", "addr stable in stall", 32'(hold_bad), 0);
    chk("R9", "ack after response", 32'(ack_cyc > rsp_cyc + 1), 1);
    @(negedge clk);
    chk("R9", "ack single pulse", 32'(host_ack), 0);
    access(1, 0, 2, 1, 32'h0BAD_F00D, d);
    chk("R9", "stalled write delivered", last_wdata, 32'h0BAD_F00D);
    rdy_wait = 0; rsp_wait = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_addr_reg();
    t_disabled();
    t_addr_form();
    t_le_read();
    t_be();
    t_stall();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule